// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block turns groups of derived clock outputs on and off when active-low stop requests arrive, and it never shortens or stretches a pulse while doing so. A single fast source clock drives two free-running reference phases. The processor group is a set of differential pairs that follow the fast reference. The bus group follows the slow reference and contains single-ended outputs and differential pairs. Every output has a free-run bit that makes it ignore stops. Every differential pair also has a float bit that leaves both legs undriven while the pair is stopped.

Each stop request is first resynchronised through two flops. The processor group then gates its outputs at the next falling boundary of its reference. The bus group samples its synchronised request only when its reference rises, and gates at the falling boundary that follows. A pair that was floating comes back in two steps: it is first driven in the parked state, with the complement leg high, and starts toggling at a later boundary. The mask bits are captured only while a group runs and has no request pending. A mask change made during a stop therefore takes effect at the next stop. Every output reports a 2-bit status.

Top module: `clk_stop_ctl`

## Requirements
- R1: After reset every output reports status 00 (running), every pair has its enable at 1, and each output follows its reference.
- R2: A running processor pair drives its true leg equal to the fast reference, with high phases of exactly CPU_HALF source cycles, and drives its complement leg as the inverse.
- R3: After `cpu_stop_n` falls, each stoppable processor pair stops between 3 and 2+2*CPU_HALF source cycles later. A stopped pair without its float bit parks with true=0, complement=1, enable=1 and status 01.
- R4: A stopped pair with its float bit set has true=0, complement=0, enable=0 and status 10 for as long as its group's synchronised request is asserted.
- R5: After a stop request is released, every stopped output of the group returns to status 00. For the processor group this happens within 3 to 2+2*CPU_HALF cycles, and for the bus group within 3+PCI_HALF to 2+3*PCI_HALF cycles. A floating pair first shows at least one cycle of status 01 with enable=1 and complement=1.
- R6: Every high pulse on a gated output lasts exactly one half period of its reference: CPU_HALF cycles for the processor group and PCI_HALF cycles for the bus group.
- R7: An output whose free-run bit is set keeps status 00 and keeps toggling with its reference during a stop.
- R8: The bus stop request takes effect only through a rising edge of `pci_ref`. A request that arrives and is withdrawn between two rising edges has no effect on any bus output.
- R9: After `pci_stop_n` falls, each stoppable bus output stops between 3+PCI_HALF and 2+3*PCI_HALF cycles later. Single-ended outputs park low with status 01. Bus pairs follow the parked and floating rules of R3 and R4.
- R10: A change to the mask bits while a group is stopped does not alter the current stop. The new values apply at the next stop of that group.
- R11: The status encoding is 00 running, 01 parked and driven, 10 floating. The code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop request, processor group |
| pci_stop_n | input | 1 | Active-low stop request, bus group |
| cpu_free | input | NCPU | Free-run mask, processor pairs |
| cpu_tri | input | NCPU | Float-when-stopped mask, processor pairs |
| pse_free | input | NSE | Free-run mask, bus single-ended outputs |
| pdf_free | input | NDF | Free-run mask, bus pairs |
| pdf_tri | input | NDF | Float-when-stopped mask, bus pairs |
| cpu_ref | output | 1 | Free-running processor reference phase |
| pci_ref | output | 1 | Free-running bus reference phase (stop sampling clock) |
| cpu_t | output | NCPU | Processor pair true legs |
| cpu_c | output | NCPU | Processor pair complement legs |
| cpu_oe | output | NCPU | Processor pair drive enables |
| cpu_st | output | 2*NCPU | Processor pair status, pair i at bits 2i+1:2i |
| pse_o | output | NSE | Bus single-ended outputs |
| pse_st | output | 2*NSE | Bus single-ended status |
| pdf_t | output | NDF | Bus pair true legs |
| pdf_c | output | NDF | Bus pair complement legs |
| pdf_oe | output | NDF | Bus pair drive enables |
| pdf_st | output | 2*NDF | Bus pair status |

## Verification
The bench goes through every combination of free-run and float masks in both groups. For each combination it measures the stop and resume latency against the window bounds. A design that skipped a synchronizer stage or gated in the middle of a phase would stop too early or emit a short pulse, and the pulse-width monitor would see it. A stop pulse withdrawn between two rising edges of the bus reference must leave the bus outputs untouched, which exposes a design that samples the request on the source clock. Two more checks target the float masks: a mask flipped during a stop must not change the current status, and a floating pair must pass through a driven parked state before it toggles again.

// File: rtl/clk_stop_ctl.sv
module clk_stop_ctl #(
  parameter int NCPU     = 2,
  parameter int NSE      = 2,
  parameter int NDF      = 2,
  parameter int CPU_HALF = 1,
  parameter int PCI_HALF = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic [NCPU-1:0]   cpu_free,
  input  logic [NCPU-1:0]   cpu_tri,
  input  logic [NSE-1:0]    pse_free,
  input  logic [NDF-1:0]    pdf_free,
  input  logic [NDF-1:0]    pdf_tri,
  output logic              cpu_ref,
  output logic              pci_ref,
  output logic [NCPU-1:0]   cpu_t,
  output logic [NCPU-1:0]   cpu_c,
  output logic [NCPU-1:0]   cpu_oe,
  output logic [2*NCPU-1:0] cpu_st,
  output logic [NSE-1:0]    pse_o,
  output logic [2*NSE-1:0]  pse_st,
  output logic [NDF-1:0]    pdf_t,
  output logic [NDF-1:0]    pdf_c,
  output logic [NDF-1:0]    pdf_oe,
  output logic [2*NDF-1:0]  pdf_st
);
  localparam int CW = $clog2(CPU_HALF + 1);
  localparam int PW = $clog2(PCI_HALF + 1);

  logic [CW-1:0]   cpu_cnt;
  logic [PW-1:0]   pci_cnt;
  logic            cpu_ph, pci_ph, cpu_run, pci_run, pci_req;
  logic [1:0]      cpu_sy, pci_sy;
  logic [NCPU-1:0] cpu_free_q, cpu_tri_q;
  logic [NSE-1:0]  pse_free_q;
  logic [NDF-1:0]  pdf_free_q, pdf_tri_q;

  logic cpu_wrap, cpu_fall, cpu_req, pci_wrap, pci_rise, pci_fall;
  assign cpu_wrap = cpu_cnt == CW'(CPU_HALF - 1);
  assign cpu_fall = cpu_wrap & cpu_ph;
  assign cpu_req  = cpu_sy[1];
  assign pci_wrap = pci_cnt == PW'(PCI_HALF - 1);
  assign pci_rise = pci_wrap & ~pci_ph;
  assign pci_fall = pci_wrap & pci_ph;
  assign cpu_ref  = cpu_ph;
  assign pci_ref  = pci_ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_cnt <= '0; cpu_ph <= 1'b0; cpu_sy <= 2'b00; cpu_run <= 1'b1;
      cpu_free_q <= '0; cpu_tri_q <= '0;
    end else begin
      cpu_cnt <= cpu_wrap ? '0 : cpu_cnt + CW'(1);
      if (cpu_wrap) cpu_ph <= ~cpu_ph;
      cpu_sy <= {cpu_sy[0], ~cpu_stop_n};
      if (cpu_fall) cpu_run <= ~cpu_req;
      if (cpu_run & ~cpu_req) begin
        cpu_free_q <= cpu_free;
        cpu_tri_q  <= cpu_tri;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pci_cnt <= '0; pci_ph <= 1'b0; pci_sy <= 2'b00; pci_req <= 1'b0; pci_run <= 1'b1;
      pse_free_q <= '0; pdf_free_q <= '0; pdf_tri_q <= '0;
    end else begin
      pci_cnt <= pci_wrap ? '0 : pci_cnt + PW'(1);
      if (pci_wrap) pci_ph <= ~pci_ph;
      pci_sy <= {pci_sy[0], ~pci_stop_n};
      if (pci_rise) pci_req <= pci_sy[1];
      if (pci_fall) pci_run <= ~pci_req;
      if (pci_run & ~pci_req) begin
        pse_free_q <= pse_free;
        pdf_free_q <= pdf_free;
        pdf_tri_q  <= pdf_tri;
      end
    end

  assert_req_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pci_req) || $fell(pci_req)) |-> $past(pci_rise));
  assert_stop_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_run) |-> $past(pci_req));

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic stp, hiz;
    assign stp = ~cpu_run & ~cpu_free_q[i];
    assign hiz = stp & cpu_tri_q[i] & cpu_req;
    assign cpu_t[i]  = cpu_ph & ~stp;
    assign cpu_c[i]  = ~hiz & ~cpu_t[i];
    assign cpu_oe[i] = ~hiz;
    assign cpu_st[2*i +: 2] = hiz ? 2'b10 : stp ? 2'b01 : 2'b00;

    assert_rise_on_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_t[i]) |-> $rose(cpu_ph));
    assert_fall_on_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_t[i]) |-> $fell(cpu_ph));
    assert_wake_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_oe[i]) |-> (cpu_c[i] && !cpu_t[i]));
    assert_status_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_st[2*i +: 2] != 2'b11);
  end

  for (genvar i = 0; i < NSE; i++) begin : g_pse
    logic stp;
    assign stp = ~pci_run & ~pse_free_q[i];
    assign pse_o[i] = pci_ph & ~stp;
    assign pse_st[2*i +: 2] = stp ? 2'b01 : 2'b00;

    assert_pse_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pse_o[i]) |-> $rose(pci_ph));
    assert_pse_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pse_o[i]) |-> $fell(pci_ph));
  end

  for (genvar i = 0; i < NDF; i++) begin : g_pdf
    logic stp, hiz;
    assign stp = ~pci_run & ~pdf_free_q[i];
    assign hiz = stp & pdf_tri_q[i] & pci_req;
    assign pdf_t[i]  = pci_ph & ~stp;
    assign pdf_c[i]  = ~hiz & ~pdf_t[i];
    assign pdf_oe[i] = ~hiz;
    assign pdf_st[2*i +: 2] = hiz ? 2'b10 : stp ? 2'b01 : 2'b00;

    assert_pdf_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdf_t[i]) |-> $rose(pci_ph));
    assert_pdf_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdf_oe[i]) |-> (pdf_c[i] && !pdf_t[i]));
    assert_pdf_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pdf_st[2*i +: 2] != 2'b11);
  end
endmodule

// File: tb/sim_clk_stop_ctl.sv
module sim_clk_stop_ctl;
  localparam int CH = 1;
  localparam int PH = 3;

  logic clk = 1'b0, rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic [1:0] cpu_free = '0, cpu_tri = '0, pse_free = '0, pdf_free = '0, pdf_tri = '0;
  logic cpu_ref, pci_ref;
  logic [1:0] cpu_t, cpu_c, cpu_oe, pse_o, pdf_t, pdf_c, pdf_oe;
  logic [3:0] cpu_st, pse_st, pdf_st;
  int nt = 0, nf = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_stop_ctl #(.NCPU(2), .NSE(2), .NDF(2), .CPU_HALF(CH), .PCI_HALF(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .cpu_free(cpu_free), .cpu_tri(cpu_tri), .pse_free(pse_free), .pdf_free(pdf_free),
    .pdf_tri(pdf_tri), .cpu_ref(cpu_ref), .pci_ref(pci_ref), .cpu_t(cpu_t), .cpu_c(cpu_c),
    .cpu_oe(cpu_oe), .cpu_st(cpu_st), .pse_o(pse_o), .pse_st(pse_st), .pdf_t(pdf_t),
    .pdf_c(pdf_c), .pdf_oe(pdf_oe), .pdf_st(pdf_st));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] code(input logic fr, input logic tr);
    return fr ? 2'b00 : tr ? 2'b10 : 2'b01;
  endfunction

  // R6 pulse-width monitor over all gated outputs
  int hl[6];
  logic [5:0] prevm = '0;
  always @(negedge clk) begin
    logic [5:0] m;
    m = {pdf_t, pse_o, cpu_t};
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) hl[i] = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        if (m[i]) hl[i]++;
        else begin
          if (prevm[i]) chk(hl[i] == (i < 2 ? CH : PH), "R6 high width", hl[i], i < 2 ? CH : PH);
          hl[i] = 0;
        end
      end
    end
    prevm = m;
  end

  task automatic cpu_stop(input logic [1:0] fr, input logic [1:0] tr, input bit setcfg);
    logic [3:0] e;
    int k;
    e = {code(fr[1], tr[1]), code(fr[0], tr[0])};
    if (setcfg) begin cpu_free = fr; cpu_tri = tr; end
    repeat (4) @(negedge clk);
    cpu_stop_n = 1'b0;
    k = 0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (k == 0 && cpu_st == e) k = n;
      if (k != 0) chk(cpu_st == e, "R3/R4 cpu status held", cpu_st, e);
    end
    if (fr != 2'b11) chk(k >= 3 && k <= 2 + 2*CH, "R3 cpu stop latency", k, 3);
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 2; i++) begin
        if (fr[i]) chk(cpu_t[i] == cpu_ref && cpu_c[i] == !cpu_ref, "R7 cpu free toggles", cpu_t[i], cpu_ref);
        else if (tr[i]) chk({cpu_t[i], cpu_c[i], cpu_oe[i]} == 3'b000, "R4 cpu floating", {cpu_t[i], cpu_c[i], cpu_oe[i]}, 0);
        else chk({cpu_t[i], cpu_c[i], cpu_oe[i]} == 3'b011, "R3 cpu parked", {cpu_t[i], cpu_c[i], cpu_oe[i]}, 3);
      end
      @(negedge clk);
    end
  endtask

  task automatic cpu_release(input logic [1:0] fr, input logic [1:0] tr);
    int k;
    bit [1:0] seen;
    cpu_stop_n = 1'b1;
    k = 0; seen = '0;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        if (cpu_st[2*i +: 2] == 2'b01 && cpu_oe[i] && cpu_c[i] && !cpu_t[i]) seen[i] = 1'b1;
      if (k == 0 && cpu_st == 4'b0000) k = n;
    end
    if (fr != 2'b11) chk(k >= 3 && k <= 2 + 2*CH, "R5 cpu resume latency", k, 3);
    else chk(k == 1, "R7 cpu all free", k, 1);
    for (int i = 0; i < 2; i++)
      if (!fr[i] && tr[i]) chk(seen[i], "R5 cpu parked before toggle", seen[i], 1);
    chk(cpu_c == ~cpu_t && cpu_oe == 2'b11, "R2 cpu complement", cpu_c, ~cpu_t);
  endtask

  task automatic pci_stop(input logic [1:0] sf, input logic [1:0] df, input logic [1:0] dt);
    logic [7:0] e;
    int k;
    bit any;
    e = {code(df[1], dt[1]), code(df[0], dt[0]), code(sf[1], 1'b0), code(sf[0], 1'b0)};
    any = (sf != 2'b11) || (df != 2'b11);
    pse_free = sf; pdf_free = df; pdf_tri = dt;
    repeat (4) @(negedge clk);
    pci_stop_n = 1'b0;
    k = 0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (k == 0 && {pdf_st, pse_st} == e) k = n;
      if (k != 0) chk({pdf_st, pse_st} == e, "R9 bus status held", {pdf_st, pse_st}, e);
    end
    if (any) chk(k >= 3 + PH && k <= 2 + 3*PH, "R9 bus stop latency", k, 3 + PH);
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 2; i++) begin
        chk(pse_o[i] == (sf[i] ? pci_ref : 1'b0), "R9/R7 bus single-ended", pse_o[i], sf[i] ? pci_ref : 1'b0);
        if (df[i]) chk(pdf_t[i] == pci_ref, "R7 bus pair free", pdf_t[i], pci_ref);
        else if (dt[i]) chk({pdf_t[i], pdf_c[i], pdf_oe[i]} == 3'b000, "R9 bus pair floating", {pdf_t[i], pdf_c[i], pdf_oe[i]}, 0);
        else chk({pdf_t[i], pdf_c[i], pdf_oe[i]} == 3'b011, "R9 bus pair parked", {pdf_t[i], pdf_c[i], pdf_oe[i]}, 3);
      end
      @(negedge clk);
    end
  endtask

  task automatic pci_release(input logic [1:0] sf, input logic [1:0] df, input logic [1:0] dt);
    int k;
    bit [1:0] seen;
    pci_stop_n = 1'b1;
    k = 0; seen = '0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++)
        if (pdf_st[2*i +: 2] == 2'b01 && pdf_oe[i] && pdf_c[i]) seen[i] = 1'b1;
      if (k == 0 && {pdf_st, pse_st} == 8'h00) k = n;
    end
    if ((sf != 2'b11) || (df != 2'b11))
      chk(k >= 3 + PH && k <= 2 + 3*PH, "R5 bus resume latency", k, 3 + PH);
    for (int i = 0; i < 2; i++)
      if (!df[i] && dt[i]) chk(seen[i], "R5 bus pair parked before toggle", seen[i], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_st == 0 && pse_st == 0 && pdf_st == 0, "R1 reset status", {cpu_st, pse_st, pdf_st}, 0);
    chk(cpu_oe == 2'b11 && pdf_oe == 2'b11, "R1 reset enables", {cpu_oe, pdf_oe}, 15);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      chk(cpu_t == {2{cpu_ref}} && cpu_c == ~cpu_t, "R2 cpu running", {cpu_t, cpu_c}, {{2{cpu_ref}}, {2{!cpu_ref}}});
      chk(pse_o == {2{pci_ref}} && pdf_t == {2{pci_ref}}, "R1 bus following", {pse_o, pdf_t}, {4{pci_ref}});
    end

    for (int m = 0; m < 16; m++) begin
      cpu_stop(m[1:0], m[3:2], 1'b1);
      cpu_release(m[1:0], m[3:2]);
    end

    // R10: mask flipped during a stop changes nothing until the next stop
    cpu_stop(2'b00, 2'b00, 1'b1);
    cpu_tri = 2'b11;
    repeat (4) @(negedge clk);
    chk(cpu_st == 4'b0101 && cpu_oe == 2'b11, "R10 mid-stop mask ignored", cpu_st, 5);
    cpu_release(2'b00, 2'b00);
    cpu_stop(2'b00, 2'b11, 1'b0);
    chk(cpu_st == 4'b1010, "R10 new mask on next stop", cpu_st, 10);
    cpu_release(2'b00, 2'b11);

    for (int m = 0; m < 64; m++) begin
      pci_stop(m[1:0], m[3:2], m[5:4]);
      pci_release(m[1:0], m[3:2], m[5:4]);
    end

    // R8: short bus request between rising edges of pci_ref
    pse_free = '0; pdf_free = '0; pdf_tri = '0;
    repeat (4) @(negedge clk);
    begin
      logic p;
      p = pci_ref;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (!p && pci_ref) break;
        p = pci_ref;
      end
    end
    pci_stop_n = 1'b0;
    @(negedge clk);
    pci_stop_n = 1'b1;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      chk(pse_st == 0 && pdf_st == 0, "R8 short request ignored", {pse_st, pdf_st}, 0);
      chk(pse_o == {2{pci_ref}}, "R8 bus keeps toggling", pse_o, {2{pci_ref}});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nt++; nf++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end
endmodule